// File: doc/BRIEF.md
# Sleep Entry and Recovery Controller

This controller sits in front of a synchronous memory array and manages its low-power sleep state. An active-high sleep request, which may change at any time relative to the clock, first passes through a flop synchronizer. The synchronized request opens an entry guard window of `GUARD` cycles. When that window ends the controller holds the array asleep. It removes the internal clock enable, forces a deselect and keeps the data outputs in high impedance.

When the request drops, a recovery guard window of `GUARD` cycles follows. The array then rests in a low-power deselected condition until the first read or write command arrives. That command is let through in the same cycle and wakes the array. During either guard window, no address strobe or write may reach the array. Any such attempt is blocked and sets a sticky violation flag. Commands that arrive while fully asleep are silently ignored. Because no command reaches the array outside the awake and low-power states, the stored contents are preserved across a sleep cycle.

Top module: `sleep_guard_ctrl`

## Requirements
- R1: After reset (rst_n low, asynchronous) the controller is awake: clk_en=1, force_desel=0, acc_block=0, dq_hiz=0, viol=0.
- R2: The sleep request is synchronized through SYNC_STAGES=2 flops. If sleep_req is high at a rising edge k, acc_block rises after edge k+2 and not earlier.
- R3: The entry window lasts exactly GUARD=2 cycles with acc_block=1, clk_en=1, force_desel=0 and dq_hiz=1. After it the controller is asleep.
- R4: While asleep, clk_en=0, force_desel=1, dq_hiz=1 and acc_block=0. strobe_out and wr_out stay 0 whatever the inputs do, and no violation is recorded.
- R5: If the synchronized request is low while asleep, a recovery window of GUARD cycles follows with acc_block=1, clk_en=0, force_desel=1 and dq_hiz=1.
- R6: During a guard window (acc_block=1), strobe_out and wr_out are 0. Any strobe_in or wr_in sets viol from the next cycle, and viol stays set until reset.
- R7: After recovery the controller is in low power (clk_en=0, force_desel=1, dq_hiz=1). It stays there until strobe_in or wr_in is high. In that cycle the command passes with clk_en=1 and force_desel=0, and from the next cycle the controller is awake.
- R8: When awake, strobe_out=strobe_in, wr_out=wr_in, dq_hiz=0, clk_en=1 and force_desel=0.
- R9: A synchronized request seen in low power starts a new entry window. The request takes priority over a command in the same cycle, but that command still passes in that cycle.
- R10: Once begun, an entry window always completes into sleep, even if the request pulse has already ended. Recovery then follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| strobe_in | input | 1 | Any address strobe requested by the bus side |
| wr_in | input | 1 | Any write control requested by the bus side |
| strobe_out | output | 1 | Address strobe allowed to reach the array |
| wr_out | output | 1 | Write allowed to reach the array |
| clk_en | output | 1 | Internal clock enable for the array |
| force_desel | output | 1 | Forced deselect of the array |
| dq_hiz | output | 1 | Data outputs held in high impedance |
| acc_block | output | 1 | Guard window active; access forbidden |
| viol | output | 1 | Sticky guard-window violation flag |

## Verification
On every cycle, the assertions check the following. Clock enable and forced deselect never conflict. Nothing reaches the array inside a guard window or while asleep. A guarded command always raises the flag, and the flag never clears without reset. A guard window never lasts a single cycle. The exact synchronizer latency, the precise length of each window, the wake-on-first-command hand-off and the forced completion of an entry after a short pulse depend on cycle counts from a stimulus. Only the bench's directed and random scenarios can show those, compared against its own state model.

// File: rtl/sleep_guard_ctrl.sv
module sleep_guard_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic strobe_in,
  input  logic wr_in,
  output logic strobe_out,
  output logic wr_out,
  output logic clk_en,
  output logic force_desel,
  output logic dq_hiz,
  output logic acc_block,
  output logic viol
);
  localparam int CW = (GUARD > 1) ? $clog2(GUARD) : 1;
  localparam logic [CW-1:0] CLOAD = CW'(GUARD - 1);

  typedef enum logic [2:0] {ST_AWAKE, ST_ENTRY, ST_ASLEEP, ST_RECOVER, ST_LOWPWR} st_t;

  st_t                    st;
  logic [CW-1:0]          cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s, cmd, pass;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};

  assign req_s = sync_q[SYNC_STAGES-1];
  assign cmd   = strobe_in | wr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_AWAKE;
      cnt <= '0;
    end else begin
      case (st)
        ST_AWAKE:
          if (req_s) begin st <= ST_ENTRY; cnt <= CLOAD; end
        ST_ENTRY:
          if (cnt == '0) st <= ST_ASLEEP;
          else           cnt <= cnt - 1'b1;
        ST_ASLEEP:
          if (!req_s) begin st <= ST_RECOVER; cnt <= CLOAD; end
        ST_RECOVER:
          if (cnt == '0) st <= ST_LOWPWR;
          else           cnt <= cnt - 1'b1;
        ST_LOWPWR:
          if (req_s)    begin st <= ST_ENTRY; cnt <= CLOAD; end
          else if (cmd) st <= ST_AWAKE;
        default: st <= ST_AWAKE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 viol <= 1'b0;
    else if (acc_block && cmd)  viol <= 1'b1;

  assign acc_block   = (st == ST_ENTRY) || (st == ST_RECOVER);
  assign pass        = (st == ST_AWAKE) || (st == ST_LOWPWR);
  assign strobe_out  = strobe_in & pass;
  assign wr_out      = wr_in & pass;
  assign clk_en      = (st == ST_AWAKE) || (st == ST_ENTRY) || ((st == ST_LOWPWR) && cmd);
  assign force_desel = (st == ST_ASLEEP) || (st == ST_RECOVER) || ((st == ST_LOWPWR) && !cmd);
  assign dq_hiz      = (st != ST_AWAKE);
endmodule

module sleep_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe_in,
  input logic wr_in,
  input logic strobe_out,
  input logic wr_out,
  input logic clk_en,
  input logic force_desel,
  input logic acc_block,
  input logic viol
);
  // R7
  en_desel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && force_desel));
  // R6
  guard_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_block |-> (!strobe_out && !wr_out));
  // R4
  sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_desel && !clk_en && !acc_block) |-> (!strobe_out && !wr_out));
  // R6
  guard_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_block && (strobe_in || wr_in)) |=> viol);
  // R6
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);
  // R3
  guard_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_block) |=> acc_block);
endmodule

bind sleep_guard_ctrl sleep_guard_chk u_sleep_guard_chk (
  .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .wr_in(wr_in),
  .strobe_out(strobe_out), .wr_out(wr_out), .clk_en(clk_en),
  .force_desel(force_desel), .acc_block(acc_block), .viol(viol)
);

// File: tb/test_sleep_guard_ctrl.sv
module test_sleep_guard_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 1'b0, strobe_in = 1'b0, wr_in = 1'b0;
  logic strobe_out, wr_out, clk_en, force_desel, dq_hiz, acc_block, viol;
  int checks = 0, failures = 0;

  // Model states: 0 awake, 1 entry, 2 asleep, 3 recover, 4 low power
  int m_st, m_cnt;
  bit m_s1, m_s2, m_viol;

  always #4 clk = ~clk;

  sleep_guard_ctrl i_sleep_guard_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .strobe_in(strobe_in),
    .wr_in(wr_in), .strobe_out(strobe_out), .wr_out(wr_out), .clk_en(clk_en),
    .force_desel(force_desel), .dq_hiz(dq_hiz), .acc_block(acc_block), .viol(viol));

  task automatic chk(input logic act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string st_tag(input int s);
    case (s)
      0: return "R8";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sleep_req = 0; strobe_in = 0; wr_in = 0;
    m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_viol = 0;
    #1;
    chk(clk_en, 1, "R1", "clk_en");
    chk(force_desel, 0, "R1", "force_desel");
    chk(acc_block, 0, "R1", "acc_block");
    chk(dq_hiz, 0, "R1", "dq_hiz");
    chk(viol, 0, "R1", "viol");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input bit rq, input bit sb, input bit wr);
    bit cmd, awk, ent, slp, rec, low, pass;
    string t;
    sleep_req = rq; strobe_in = sb; wr_in = wr;
    #1;
    cmd = sb | wr;
    awk = (m_st == 0); ent = (m_st == 1); slp = (m_st == 2);
    rec = (m_st == 3); low = (m_st == 4);
    pass = awk | low;
    t = st_tag(m_st);
    chk(strobe_out, sb & pass, (ent | rec) ? "R6" : t, "strobe_out");
    chk(wr_out, wr & pass, (ent | rec) ? "R6" : t, "wr_out");
    chk(clk_en, awk | ent | (low & cmd), t, "clk_en");
    chk(force_desel, slp | rec | (low & !cmd), t, "force_desel");
    chk(acc_block, ent | rec, t, "acc_block");
    chk(dq_hiz, !awk, t, "dq_hiz");
    chk(viol, m_viol, "R6", "viol");
    @(posedge clk);
    if ((ent | rec) && cmd) m_viol = 1;
    case (m_st)
      0: if (m_s2) begin m_st = 1; m_cnt = 1; end
      1: if (m_cnt == 0) m_st = 2; else m_cnt--;
      2: if (!m_s2) begin m_st = 3; m_cnt = 1; end
      3: if (m_cnt == 0) m_st = 4; else m_cnt--;
      default: if (m_s2) begin m_st = 1; m_cnt = 1; end else if (cmd) m_st = 0;
    endcase
    m_s2 = m_s1; m_s1 = rq;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    step(0, 1, 0); step(0, 1, 1);                    // R8 pass-through
    step(1, 0, 0); step(1, 0, 0);
    chk(acc_block, 0, "R2", "acc_block before sync latency");
    step(1, 0, 0);
    chk(acc_block, 1, "R2", "acc_block after two sync stages");
    step(1, 1, 0);                                   // R6 strobe in entry
    chk(viol, 1, "R6", "viol after guarded strobe");
    step(1, 0, 0);
    chk(force_desel, 1, "R3", "asleep after GUARD entry cycles");
    step(1, 1, 1); step(1, 0, 1); step(1, 1, 0);     // R4 ignored while asleep
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    chk(acc_block, 1, "R5", "recovery window");
    step(0, 0, 0); step(0, 0, 0);
    chk(clk_en, 0, "R7", "low power holds clock off");
    step(0, 0, 0); step(0, 0, 0);
    step(0, 0, 1);                                   // R7 wake on write
    chk(dq_hiz, 0, "R7", "awake after first command");
    chk(viol, 1, "R6", "viol sticky");
    do_reset();
    // R9: request again from low power
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);     // R10 short pulse
    step(0, 0, 0);
    chk(acc_block, 1, "R10", "entry runs despite ended pulse");
    step(0, 0, 0);
    chk(dq_hiz, 1, "R10", "asleep reached");
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    chk(force_desel, 1, "R9", "low power before re-request");
    step(1, 0, 0); step(1, 0, 0); step(1, 1, 0);
    chk(acc_block, 1, "R9", "entry from low power");
    step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      bit rq;
      rq = (($urandom % 12) == 0) ? !sleep_req : sleep_req;
      step(rq, ($urandom % 4) == 0, ($urandom % 6) == 0);
      if (i == 2000) do_reset();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule